// File: doc/BRIEF.md
# Pipelined Unsigned Divide-by-Three Unit

This unit returns the quotient and remainder of an unsigned operand divided by the constant three. It does not iterate. Each operand is multiplied by a fixed reciprocal constant, and a fixed right shift then yields the truncated quotient. The remainder is recovered by subtracting three times the quotient from the operand. The unit accepts one operation per clock and returns every result exactly two cycles later, in issue order, with no back-pressure.

A second, narrow path serves colour averaging. The caller supplies several 8-bit channel samples and raises the averaging select. The unit adds the samples and divides the small sum by three. This path uses its own reciprocal and shift, both derived from the sum width, and they are exact over the whole range of possible sums. A per-cycle select chooses the path, so the two kinds of operation can be mixed freely in one stream.

Top module: `div3_unit`

## Requirements
- R1: When `in_avg` is 0, `out_quot` equals floor(`in_word` / 3) for every 32-bit unsigned `in_word`, including 0, 1, 2, 3 and 0xFFFFFFFF.
- R2: `out_rem` equals the operand modulo 3. It is always 0, 1 or 2.
- R3: When `in_avg` is 1, the operand is the sum of the three channels in `in_chans`. Channel k occupies bits [8k+7:8k]. The sum lies in 0..765. `out_quot` is floor(sum / 3), zero-extended, so it never exceeds 255. `out_rem` is sum modulo 3. The result is exact for every reachable sum.
- R4: A result appears with `out_valid` high exactly two rising edges after the edge that samples `in_valid` high.
- R5: Operations may be issued on every consecutive cycle. Each one yields its own result, in order, with no stall or loss.
- R6: `rst` is synchronous and active high. `out_valid` is low while reset is applied and stays low for the two cycles after release. Operations in flight when reset arrives produce no result.
- R7: A cycle with `in_valid` low produces `out_valid` low two cycles later, whatever values the data inputs hold.
- R8: In word mode the channel inputs do not affect the result. In averaging mode `in_word` does not affect the result. The mode may change on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| in_avg | input | 1 | 1 selects channel averaging, 0 selects 32-bit word division |
| in_word | input | 32 | Dividend in word mode |
| in_chans | input | 24 | Three 8-bit channel samples, channel k at bits [8k+7:8k] |
| out_valid | output | 1 | Result strobe, two cycles after issue |
| out_quot | output | 32 | Quotient |
| out_rem | output | 2 | Remainder, 0 to 2 |

## Verification
A wrong reciprocal, a wrong shift or a wrong remainder subtraction corrupts the quotient or remainder of the very operation that meets it. The error shows at the ports two cycles after issue. A slip in the narrow path only appears for particular sums, so every sum from 0 to 765 is driven, along with the 32-bit extremes near multiples of three. A fault in the valid or mode pipeline shows up differently: results arrive a cycle early or late, a result is taken from the wrong path, or a reset fails to flush an operation. Streams that mix modes, insert gaps and reset part-way through expose these faults within a few cycles of the event.

// File: rtl/div3_pkg.sv
package div3_pkg;

    typedef enum logic {
        MODE_WORD = 1'b0,
        MODE_AVG  = 1'b1
    } div3_mode_e;

    // Control word travelling beside the data through both stages
    typedef struct packed {
        logic       vld;
        div3_mode_e mode;
    } div3_tag_t;

    // Reciprocal of three scaled by 2^(w+1), rounded up; exact for w-bit
    // unsigned operands when the product is shifted right by w+1.
    function automatic logic [63:0] recip_magic(input int unsigned w);
        return ((64'd1 << (w + 1)) + 64'd2) / 64'd3;
    endfunction

    // Width needed to hold the sum of n samples of cw bits each
    function automatic int unsigned sum_width(input int unsigned cw, input int unsigned n);
        return cw + $clog2(n);
    endfunction

endpackage

// File: rtl/div3_chan_sum.sv
module div3_chan_sum #(
    parameter int unsigned CHAN_W = 8,
    parameter int unsigned N_CHAN = 3,
    parameter int unsigned SUM_W  = 10
) (
    input  logic [N_CHAN*CHAN_W-1:0] chans_i,
    output logic [SUM_W-1:0]         sum_o
);

    logic [SUM_W-1:0] partial [N_CHAN+1];

    assign partial[0] = '0;

    for (genvar g = 0; g < N_CHAN; g++) begin : g_acc
        assign partial[g+1] = partial[g] + SUM_W'(chans_i[g*CHAN_W +: CHAN_W]);
    end

    assign sum_o = partial[N_CHAN];

endmodule

// File: rtl/div3_lane.sv
module div3_lane
    import div3_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] x_i,
    output logic         vld_o,
    output logic [W-1:0] q_o,
    output logic [1:0]   r_o
);

    localparam int unsigned PW    = 2 * W;
    localparam int unsigned SHIFT = W + 1;
    localparam logic [W-1:0] MAGIC = W'(recip_magic(W));

    // Stage 1: operand times reciprocal
    logic          s1_vld;
    logic [W-1:0]  s1_x;
    logic [PW-1:0] s1_prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
        end else begin
            s1_vld <= vld_i;
        end
        s1_x    <= x_i;
        s1_prod <= {{W{1'b0}}, x_i} * {{W{1'b0}}, MAGIC};
    end

    // Stage 2: drop the fraction, rebuild the remainder
    logic [PW-SHIFT-1:0] q_raw;
    logic [SHIFT-1:0]    frac_unused;
    logic [W-1:0]        q_c;
    logic [W+1:0]        tri_c;
    logic [W+1:0]        rem_c;

    assign {q_raw, frac_unused} = s1_prod;
    assign q_c   = W'(q_raw);
    assign tri_c = {2'b00, q_c} + {1'b0, q_c, 1'b0};
    assign rem_c = {2'b00, s1_x} - tri_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= s1_vld;
        end
        q_o <= q_c;
        r_o <= rem_c[1:0];
    end

    AST_QUOT_NOT_OVER: assert property (@(posedge clk) disable iff (rst)
        s1_vld |-> (tri_c <= {2'b00, s1_x})); // R1
    AST_REM_RANGE: assert property (@(posedge clk) disable iff (rst)
        s1_vld |-> (rem_c < (W+2)'(3))); // R2

endmodule

// File: rtl/div3_unit.sv
module div3_unit
    import div3_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned CHAN_W = 8,
    parameter int unsigned N_CHAN = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_avg,
    input  logic [WORD_W-1:0]        in_word,
    input  logic [N_CHAN*CHAN_W-1:0] in_chans,
    output logic                     out_valid,
    output logic [WORD_W-1:0]        out_quot,
    output logic [1:0]               out_rem
);

    localparam int unsigned SUM_W    = sum_width(CHAN_W, N_CHAN);
    localparam int unsigned MAX_SUM  = N_CHAN * ((1 << CHAN_W) - 1);
    localparam int unsigned MAX_AVGQ = MAX_SUM / 3;

    div3_mode_e in_mode;
    assign in_mode = in_avg ? MODE_AVG : MODE_WORD;

    // Control pipeline, two stages to match the lanes
    div3_tag_t tag_s1, tag_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_s1 <= '0;
            tag_s2 <= '0;
        end else begin
            tag_s1 <= '{vld: in_valid, mode: in_mode};
            tag_s2 <= tag_s1;
        end
    end

    // Channel sum feeding the narrow lane
    logic [SUM_W-1:0] chan_sum;

    div3_chan_sum #(
        .CHAN_W (CHAN_W),
        .N_CHAN (N_CHAN),
        .SUM_W  (SUM_W)
    ) u_sum (
        .chans_i (in_chans),
        .sum_o   (chan_sum)
    );

    logic              wide_vld, nar_vld;
    logic [WORD_W-1:0] wide_q;
    logic [SUM_W-1:0]  nar_q;
    logic [1:0]        wide_r, nar_r;

    div3_lane #(.W(WORD_W)) u_wide (
        .clk   (clk),
        .rst   (rst),
        .vld_i (in_valid && (in_mode == MODE_WORD)),
        .x_i   (in_word),
        .vld_o (wide_vld),
        .q_o   (wide_q),
        .r_o   (wide_r)
    );

    div3_lane #(.W(SUM_W)) u_narrow (
        .clk   (clk),
        .rst   (rst),
        .vld_i (in_valid && (in_mode == MODE_AVG)),
        .x_i   (chan_sum),
        .vld_o (nar_vld),
        .q_o   (nar_q),
        .r_o   (nar_r)
    );

    assign out_valid = tag_s2.vld;
    assign out_quot  = (tag_s2.mode == MODE_AVG) ? WORD_W'(nar_q) : wide_q;
    assign out_rem   = (tag_s2.mode == MODE_AVG) ? nar_r : wide_r;

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wide_vld, nar_vld})); // R8
    AST_LANE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        tag_s2.vld |-> ((tag_s2.mode == MODE_AVG) ? nar_vld : wide_vld)); // R4
    AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2))); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(in_valid, 2)) |-> !out_valid); // R7
    AST_AVG_BOUND: assert property (@(posedge clk) disable iff (rst)
        (out_valid && tag_s2.mode == MODE_AVG) |-> (out_quot <= WORD_W'(MAX_AVGQ))); // R3

endmodule

// File: tb/div3_unit_tb.sv
`timescale 1ns/1ps
module div3_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_avg = 1'b0;
    logic [31:0] in_word = '0;
    logic [23:0] in_chans = '0;
    logic        out_valid;
    logic [31:0] out_quot;
    logic [1:0]  out_rem;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected results: index 0 just issued, index 1 due now
    logic        pv [2];
    logic [31:0] pq [2];
    logic [1:0]  pr [2];
    string       pt [2];

    always #2.5 clk = ~clk;

    div3_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_avg    (in_avg),
        .in_word   (in_word),
        .in_chans  (in_chans),
        .out_valid (out_valid),
        .out_quot  (out_quot),
        .out_rem   (out_rem)
    );

    task automatic check_out();
        n_cmp++;
        if (out_valid !== pv[1]) begin
            n_bad++;
            $display("FAIL %s R4 valid: actual=%b expected=%b", pt[1], out_valid, pv[1]);
        end else if (pv[1]) begin
            n_cmp++;
            if (out_quot !== pq[1]) begin
                n_bad++;
                $display("FAIL %s quotient: actual=%0d expected=%0d", pt[1], out_quot, pq[1]);
            end
            n_cmp++;
            if (out_rem !== pr[1]) begin
                n_bad++;
                $display("FAIL %s R2 remainder: actual=%0d expected=%0d", pt[1], out_rem, pr[1]);
            end
        end
    endtask

    task automatic step(input logic r, input logic v, input logic avg,
                        input logic [31:0] w, input logic [23:0] ch, input string tag);
        longint unsigned val;
        @(negedge clk);
        check_out();
        pv[1] = pv[0]; pq[1] = pq[0]; pr[1] = pr[0]; pt[1] = pt[0];
        if (r) begin
            pv[1] = 1'b0;
            pt[1] = "R6";
        end
        rst      = r;
        in_valid = v;
        in_avg   = avg;
        in_word  = w;
        in_chans = ch;
        if (avg) val = longint'(ch[7:0]) + longint'(ch[15:8]) + longint'(ch[23:16]);
        else     val = longint'(w);
        pq[0] = 32'(val / 3);
        pr[0] = 2'(val % 3);
        pv[0] = v && !r;
        pt[0] = tag;
    endtask

    task automatic issue_word(input logic [31:0] w, input string tag);
        step(1'b0, 1'b1, 1'b0, w, 24'($urandom), tag);
    endtask

    task automatic issue_avg(input logic [23:0] ch, input string tag);
        step(1'b0, 1'b1, 1'b1, $urandom, ch, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'($urandom), $urandom, 24'($urandom), "R7");
    endtask

    initial begin
        pv[0] = 1'b0; pv[1] = 1'b0;
        pq[0] = '0; pq[1] = '0; pr[0] = '0; pr[1] = '0;
        pt[0] = "R6"; pt[1] = "R6";

        // R6: reset held, outputs quiet
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 32'd9, 24'd0, "R6");
        idle(3);

        // R1 R2: word corners
        issue_word(32'd0, "R1");
        issue_word(32'd1, "R1");
        issue_word(32'd2, "R1");
        issue_word(32'd3, "R1");
        issue_word(32'd4, "R1");
        issue_word(32'hFFFFFFFF, "R1");
        issue_word(32'hFFFFFFFE, "R1");
        issue_word(32'hFFFFFFFD, "R1");
        issue_word(32'hAAAAAAAA, "R1");
        issue_word(32'h80000000, "R1");
        issue_word(32'h7FFFFFFF, "R1");
        for (int k = 0; k < 32; k++) begin
            issue_word(32'd1 << k, "R1");
            issue_word((32'd1 << k) - 32'd1, "R1");
        end

        // R5: back-to-back random words
        for (int i = 0; i < 3000; i++) issue_word($urandom, "R5");

        // R7: gaps with changing junk on the data inputs
        for (int i = 0; i < 200; i++) begin
            issue_word($urandom, "R7");
            idle(1 + (i % 3));
        end

        // R3: every reachable sum, channels filled in three arrangements
        for (int s = 0; s <= 765; s++) begin
            int a, b, c;
            a = (s > 255) ? 255 : s;
            b = ((s - a) > 255) ? 255 : (s - a);
            c = s - a - b;
            issue_avg({8'(c), 8'(b), 8'(a)}, "R3");
            issue_avg({8'(a), 8'(c), 8'(b)}, "R3");
            issue_avg({8'(b), 8'(a), 8'(c)}, "R3");
        end
        issue_avg(24'hFFFFFF, "R3");
        issue_avg(24'h000000, "R3");
        for (int i = 0; i < 2000; i++) issue_avg(24'($urandom), "R3");

        // R8: modes alternate each cycle with junk on the unused input
        for (int i = 0; i < 1500; i++) begin
            if (i % 2 == 0) issue_avg(24'($urandom), "R8");
            else            issue_word($urandom, "R8");
        end

        // R6: reset in the middle of a stream flushes in-flight work
        issue_word(32'd300, "R6");
        issue_avg(24'h010203, "R6");
        step(1'b1, 1'b1, 1'b0, 32'd99, 24'd0, "R6");
        step(1'b1, 1'b0, 1'b0, 32'd0, 24'd0, "R6");
        step(1'b0, 1'b0, 1'b0, 32'd0, 24'd0, "R6");
        step(1'b0, 1'b0, 1'b0, 32'd0, 24'd0, "R6");
        issue_word(32'd301, "R6");
        issue_avg(24'h0A0B0C, "R6");

        idle(4);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R5 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule